// File: doc/BRIEF.md
# Double-Buffered Serial Transceiver with Parity

This block is a full-duplex asynchronous serial port for eight-bit characters. Each direction places a one-byte holding register in front of a shift register. Software, or a neighbouring block, can therefore queue the next transmit byte while the current one is still on the line. On the receive side, one finished byte can wait to be read while the next one is still arriving.

Parity can be off, even or odd, and a frame ends with one or two stop bits. A programmable divider sets the bit rate. Its input events come either from every system clock cycle or from the rising edges of a slower alternate clock, which is synchronised inside the block. The receiver oversamples each bit sixteen times and decides at mid-bit. Three interrupt pulses come out of the block: receive-complete, transmit-done and error. Parity, framing and overrun errors each have their own sticky flag.

Top module: `uart_dbuf`

## Requirements
- R1: After reset, txd is high, both holding-full outputs are low, all three error flags are low and no interrupt pulse is raised.
- R2: A transmitted frame is one low start bit, then the eight data bits least significant first, then the optional parity bit, then the stop bits (high). Each bit lasts 16 baud ticks.
- R3: par_mode encoding: 2'b00 means no parity, 2'b01 means even, 2'b10 means odd and 2'b11 means no parity. Even parity makes the number of ones in data plus parity even. Odd parity makes it odd.
- R4: two_stop=1 gives two stop bits and two_stop=0 gives one. irq_tx is a one-cycle pulse at the end of the last stop bit, and txd is high during it.
- R5: tx_load writes tx_data into the transmit holding register when that register is empty, or in the same cycle as its content moves to the shift register. A tx_load while the register is full and no move is happening is ignored. The holding register moves into the idle shift register on the next clock.
- R6: A baud tick occurs once every baud_div+1 source events. With use_alt=0 each system clock cycle is a source event. With use_alt=1 each synchronised rising edge of clk_alt is a source event.
- R7: A received frame stores its byte in rx_data, raises rx_hold_full and pulses irq_rx for one cycle. rx_read clears rx_hold_full.
- R8: A low pulse on rxd that is high again at the midpoint of the start bit is discarded. No byte is stored and no interrupt is raised.
- R9: When parity is enabled and the received parity bit disagrees with the data, err_parity is set. The byte is still stored.
- R10: A low level sampled in a stop bit sets err_frame.
- R11: If a byte completes while rx_hold_full is high and rx_read is not asserted, err_overrun is set, the new byte is dropped and rx_data keeps the old byte.
- R12: Error flags stay set until err_clr is asserted. irq_err pulses for one cycle on each error event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_alt | input | 1 | Alternate baud source clock |
| use_alt | input | 1 | 1 selects clk_alt edges as the baud source |
| baud_div | input | DIV_W | Divider value; tick every baud_div+1 source events |
| par_mode | input | 2 | Parity selection (see R3) |
| two_stop | input | 1 | 1 selects two stop bits |
| tx_data | input | 8 | Byte to queue for transmission |
| tx_load | input | 1 | Write strobe for tx_data |
| tx_hold_full | output | 1 | Transmit holding register occupied |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Received byte in the holding register |
| rx_hold_full | output | 1 | Receive holding register occupied |
| rx_read | input | 1 | Frees the receive holding register |
| err_clr | input | 1 | Clears all error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| irq_rx | output | 1 | Pulse per stored received byte |
| irq_tx | output | 1 | Pulse per transmitted frame |
| irq_err | output | 1 | Pulse per error event |

## Verification
A write to the transmit holding register can fall in the same cycle in which the previous byte leaves that register for the shift register. The bench provokes this by holding tx_load high for three consecutive cycles with three different bytes while the line is idle. The first byte is taken at once and the second lands exactly in the hand-off cycle, so it must be kept. The third arrives while the register is full and the shifter is busy, so it must be dropped. The bench judges the result on the line: exactly the first two bytes must appear in order, irq_tx must pulse exactly twice, and the holding register must end empty.

// File: rtl/uart_dbuf_pkg.sv
`timescale 1ns/1ps
package uart_dbuf_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_START,
      FS_DATA,
      FS_PAR,
      FS_STOP
   } frame_st_e;

   // parity active for even (01) and odd (10)
   function automatic logic par_on(input logic [1:0] mode);
      return (mode == 2'b01) || (mode == 2'b10);
   endfunction

   function automatic logic par_bit(input logic [BYTE_W-1:0] d, input logic [1:0] mode);
      return (^d) ^ (mode == 2'b10);
   endfunction

endpackage

// File: rtl/uart_dbuf_baud.sv
`timescale 1ns/1ps
module uart_dbuf_baud #(
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit ALT_EN      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_alt,
   input  logic             use_alt,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic             src_ev;
   logic [DIV_W-1:0] cnt;

   generate
      if (ALT_EN) begin : g_alt
         logic [SYNC_STAGES:0] alt_sh;
         logic                 alt_edge;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) alt_sh <= '0;
            else        alt_sh <= {alt_sh[SYNC_STAGES-1:0], clk_alt};
         end

         assign alt_edge = alt_sh[SYNC_STAGES-1] & ~alt_sh[SYNC_STAGES];
         assign src_ev   = use_alt ? alt_edge : 1'b1;

         // R6: synchronised alternate edges never arrive on back-to-back cycles
         a_r6_alt_sparse: assert property (@(posedge clk) disable iff (!rst_n)
            (use_alt && tick) |=> (!tick || !use_alt));
      end else begin : g_sys
         logic unused_alt;
         assign unused_alt = clk_alt ^ use_alt;
         assign src_ev     = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (src_ev) cnt <= (cnt >= div) ? '0 : cnt + 1'b1;
   end

   assign tick = src_ev && (cnt >= div);

endmodule

// File: rtl/uart_dbuf_tx.sv
`timescale 1ns/1ps
module uart_dbuf_tx
   import uart_dbuf_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        par_mode,
   input  logic              two_stop,
   input  logic              ld,
   input  logic [BYTE_W-1:0] ld_data,
   output logic              hold_full,
   output logic              txd,
   output logic              irq_done
);

   localparam int SUB_W = $clog2(OVS);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

   frame_st_e         st;
   logic [SUB_W-1:0]  sub;
   logic [2:0]        bitn;
   logic [BYTE_W-1:0] hold, sh;
   logic              pb, stop2, take;

   assign take = (st == FS_IDLE) && hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
      end else if (ld && (!hold_full || take)) begin
         hold      <= ld_data;
         hold_full <= 1'b1;
      end else if (take) begin
         hold_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FS_IDLE;
         sub      <= '0;
         bitn     <= '0;
         sh       <= '0;
         pb       <= 1'b0;
         stop2    <= 1'b0;
         irq_done <= 1'b0;
      end else begin
         irq_done <= 1'b0;
         if (st == FS_IDLE) begin
            if (hold_full) begin
               sh  <= hold;
               pb  <= par_bit(hold, par_mode);
               st  <= FS_START;
               sub <= '0;
            end
         end else if (tick) begin
            if (sub == SUB_LAST) begin
               sub <= '0;
               case (st)
                  FS_START: begin
                     st   <= FS_DATA;
                     bitn <= '0;
                  end
                  FS_DATA: begin
                     sh   <= sh >> 1;
                     bitn <= bitn + 1'b1;
                     if (bitn == 3'd7) begin
                        st    <= par_on(par_mode) ? FS_PAR : FS_STOP;
                        stop2 <= 1'b0;
                     end
                  end
                  FS_PAR: begin
                     st    <= FS_STOP;
                     stop2 <= 1'b0;
                  end
                  FS_STOP: begin
                     if (two_stop && !stop2) begin
                        stop2 <= 1'b1;
                     end else begin
                        st       <= FS_IDLE;
                        irq_done <= 1'b1;
                     end
                  end
                  default: st <= FS_IDLE;
               endcase
            end else begin
               sub <= sub + 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (st)
         FS_START: txd = 1'b0;
         FS_DATA:  txd = sh[0];
         FS_PAR:   txd = pb;
         default:  txd = 1'b1;
      endcase
   end

   // R5: a queued byte enters the idle shifter on the next clock and starts a frame
   a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FS_IDLE && hold_full) |=> (st == FS_START && !txd));

   // R4: done pulse coincides with the line back at its high level
   a_r4_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |-> txd);

endmodule

// File: rtl/uart_dbuf_rx.sv
`timescale 1ns/1ps
module uart_dbuf_rx
   import uart_dbuf_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic [1:0]        par_mode,
   input  logic              two_stop,
   input  logic              rd,
   input  logic              err_clr,
   output logic [BYTE_W-1:0] data,
   output logic              full,
   output logic              irq_rx,
   output logic              irq_err,
   output logic              e_par,
   output logic              e_frm,
   output logic              e_ovr
);

   localparam int SUB_W = $clog2(OVS);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
   localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

   logic [SYNC_STAGES-1:0] rs;
   logic                   rx_s;
   frame_st_e              st;
   logic [SUB_W-1:0]       sub;
   logic [2:0]             bitn;
   logic [BYTE_W-1:0]      sh;
   logic                   armed, stop2, par_bad;
   logic                   samp, stop_now, fin, store;
   logic                   ev_par, ev_frm, ev_ovr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rs <= '1;
      else        rs <= {rs[SYNC_STAGES-2:0], rxd};
   end
   assign rx_s = rs[SYNC_STAGES-1];

   always_comb begin
      samp     = tick && (sub == SUB_LAST);
      stop_now = (st == FS_STOP) && samp;
      fin      = stop_now && (!rx_s || !two_stop || stop2);
      ev_frm   = stop_now && !rx_s;
      ev_par   = fin && par_on(par_mode) && par_bad;
      ev_ovr   = fin && full && !rd;
      store    = fin && !(full && !rd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FS_IDLE;
         sub     <= '0;
         bitn    <= '0;
         sh      <= '0;
         armed   <= 1'b0;
         stop2   <= 1'b0;
         par_bad <= 1'b0;
      end else begin
         case (st)
            FS_IDLE: begin
               if (rx_s) armed <= 1'b1;
               if (tick && !rx_s && armed) begin
                  st    <= FS_START;
                  sub   <= '0;
                  armed <= 1'b0;
               end
            end
            FS_START: if (tick) begin
               if (sub == SUB_MID) begin
                  sub <= '0;
                  if (rx_s) begin
                     st <= FS_IDLE;
                  end else begin
                     st      <= FS_DATA;
                     bitn    <= '0;
                     par_bad <= 1'b0;
                  end
               end else begin
                  sub <= sub + 1'b1;
               end
            end
            FS_DATA: if (tick) begin
               if (sub == SUB_LAST) begin
                  sub  <= '0;
                  sh   <= {rx_s, sh[BYTE_W-1:1]};
                  bitn <= bitn + 1'b1;
                  if (bitn == 3'd7) begin
                     st    <= par_on(par_mode) ? FS_PAR : FS_STOP;
                     stop2 <= 1'b0;
                  end
               end else begin
                  sub <= sub + 1'b1;
               end
            end
            FS_PAR: if (tick) begin
               if (sub == SUB_LAST) begin
                  sub     <= '0;
                  par_bad <= rx_s != par_bit(sh, par_mode);
                  st      <= FS_STOP;
                  stop2   <= 1'b0;
               end else begin
                  sub <= sub + 1'b1;
               end
            end
            FS_STOP: if (tick) begin
               if (sub == SUB_LAST) begin
                  sub <= '0;
                  if (fin) st    <= FS_IDLE;
                  else     stop2 <= 1'b1;
               end else begin
                  sub <= sub + 1'b1;
               end
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data    <= '0;
         full    <= 1'b0;
         irq_rx  <= 1'b0;
         irq_err <= 1'b0;
         e_par   <= 1'b0;
         e_frm   <= 1'b0;
         e_ovr   <= 1'b0;
      end else begin
         if (store)   full <= 1'b1;
         else if (rd) full <= 1'b0;
         if (store) data <= sh;
         irq_rx  <= store;
         irq_err <= ev_par | ev_frm | ev_ovr;
         e_par   <= (e_par && !err_clr) || ev_par;
         e_frm   <= (e_frm && !err_clr) || ev_frm;
         e_ovr   <= (e_ovr && !err_clr) || ev_ovr;
      end
   end

   // R7: a receive pulse always comes with an occupied holding register
   a_r7_irq_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> full);

   // R11: an overrun leaves the held byte untouched
   a_r11_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ovr |=> $stable(data));

   // R12: clear without a competing event empties the parity flag
   a_r12_clear_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !ev_par) |=> !e_par);

   // R12: every error pulse is backed by a set flag
   a_r12_irq_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> (e_par || e_frm || e_ovr));

endmodule

// File: rtl/uart_dbuf.sv
`timescale 1ns/1ps
module uart_dbuf
   import uart_dbuf_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit ALT_EN      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_alt,
   input  logic             use_alt,
   input  logic [DIV_W-1:0] baud_div,
   input  logic [1:0]       par_mode,
   input  logic             two_stop,
   input  logic [7:0]       tx_data,
   input  logic             tx_load,
   output logic             tx_hold_full,
   output logic             txd,
   input  logic             rxd,
   output logic [7:0]       rx_data,
   output logic             rx_hold_full,
   input  logic             rx_read,
   input  logic             err_clr,
   output logic             err_parity,
   output logic             err_frame,
   output logic             err_overrun,
   output logic             irq_rx,
   output logic             irq_tx,
   output logic             irq_err
);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be positive");
      end
   endgenerate

   logic tick;

   uart_dbuf_baud #(
      .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES), .ALT_EN(ALT_EN)
   ) u_baud (
      .clk(clk), .rst_n(rst_n), .clk_alt(clk_alt), .use_alt(use_alt),
      .div(baud_div), .tick(tick)
   );

   uart_dbuf_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .par_mode(par_mode),
      .two_stop(two_stop), .ld(tx_load), .ld_data(tx_data),
      .hold_full(tx_hold_full), .txd(txd), .irq_done(irq_tx)
   );

   uart_dbuf_rx #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_mode(par_mode),
      .two_stop(two_stop), .rd(rx_read), .err_clr(err_clr),
      .data(rx_data), .full(rx_hold_full), .irq_rx(irq_rx), .irq_err(irq_err),
      .e_par(err_parity), .e_frm(err_frame), .e_ovr(err_overrun)
   );

endmodule

// File: tb/uart_dbuf_bench.sv
`timescale 1ns/1ps
module uart_dbuf_bench;

   logic        clk = 1'b0, rst_n = 1'b0, clk_alt = 1'b0, use_alt = 1'b0;
   logic [15:0] baud_div = '0;
   logic [1:0]  par_mode = 2'b00;
   logic        two_stop = 1'b0;
   logic [7:0]  tx_data = '0;
   logic        tx_load = 1'b0, rxd = 1'b1, rx_read = 1'b0, err_clr = 1'b0;
   logic        tx_hold_full, txd, rx_hold_full, err_parity, err_frame, err_overrun;
   logic        irq_rx, irq_tx, irq_err;
   logic [7:0]  rx_data;

   always #2.5 clk = ~clk;
   always #10  clk_alt = ~clk_alt;

   uart_dbuf u_uart_dbuf (
      .clk(clk), .rst_n(rst_n), .clk_alt(clk_alt), .use_alt(use_alt),
      .baud_div(baud_div), .par_mode(par_mode), .two_stop(two_stop),
      .tx_data(tx_data), .tx_load(tx_load), .tx_hold_full(tx_hold_full),
      .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_hold_full(rx_hold_full),
      .rx_read(rx_read), .err_clr(err_clr), .err_parity(err_parity),
      .err_frame(err_frame), .err_overrun(err_overrun), .irq_rx(irq_rx),
      .irq_tx(irq_tx), .irq_err(irq_err)
   );

   int n_chk = 0, n_bad = 0;
   int cyc = 0, n_itx = 0, n_irx = 0, n_ierr = 0, itx_cyc = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (irq_tx) begin n_itx <= n_itx + 1; itx_cyc <= cyc + 1; end
      if (irq_rx) n_irx <= n_irx + 1;
      if (irq_err) n_ierr <= n_ierr + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(5 * 190000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         report();
         $finish;
      end
   end

   task automatic tick_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tx_write(input logic [7:0] d);
      @(negedge clk); tx_data = d; tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
   endtask

   // samples one frame from txd; returns data, parity, stop levels, fall-to-irq time
   task automatic tx_capture(input int bt, input bit pon, input bit ts,
                             output logic [7:0] d, output logic pb,
                             output logic stops_ok, output int dt);
      int t0, k0, lim;
      lim = 0;
      while (txd && lim < 20 * bt) begin @(negedge clk); lim++; end
      t0 = cyc; k0 = n_itx;
      tick_n(bt / 2);
      stops_ok = !txd;
      for (int i = 0; i < 8; i++) begin tick_n(bt); d[i] = txd; end
      pb = 1'b0;
      if (pon) begin tick_n(bt); pb = txd; end
      tick_n(bt); stops_ok = stops_ok & txd;
      if (ts) begin tick_n(bt); stops_ok = stops_ok & txd; end
      lim = 0;
      while (n_itx == k0 && lim < 2 * bt) begin @(negedge clk); lim++; end
      dt = itx_cyc - t0;
   endtask

   task automatic rx_send(input logic [7:0] d, input logic [1:0] pm, input bit ts,
                          input int bt, input bit flip, input bit bad_stop);
      @(negedge clk); rxd = 1'b0; tick_n(bt - 1);
      for (int i = 0; i < 8; i++) begin rxd = d[i]; tick_n(bt); end
      if (pm == 2'b01 || pm == 2'b10) begin
         rxd = (^d) ^ (pm == 2'b10) ^ flip; tick_n(bt);
      end
      rxd = !bad_stop; tick_n(bt);
      rxd = 1'b1; if (ts) tick_n(bt);
      tick_n(bt);
   endtask

   task automatic pulse_read();
      @(negedge clk); rx_read = 1'b1; @(negedge clk); rx_read = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
   endtask

   // [13]=alt [12:11]=div [10]=two_stop [9:8]=par_mode [7:0]=data
   localparam logic [13:0] VEC [0:5] = '{
      {1'b0, 2'd0, 1'b0, 2'b00, 8'hA5},
      {1'b0, 2'd1, 1'b0, 2'b01, 8'h3C},
      {1'b0, 2'd0, 1'b1, 2'b10, 8'h81},
      {1'b0, 2'd2, 1'b1, 2'b01, 8'h7F},
      {1'b1, 2'd0, 1'b0, 2'b10, 8'h00},
      {1'b0, 2'd0, 1'b0, 2'b11, 8'hFF}
   };

   initial begin
      logic [7:0] d;
      logic pb, sok;
      int dt, k, e;

      tick_n(4);
      rst_n = 1'b1;
      tick_n(3);
      // R1: reset state
      chk("R1 txd idle", txd, 1);
      chk("R1 tx hold empty", tx_hold_full, 0);
      chk("R1 rx hold empty", rx_hold_full, 0);
      chk("R1 errors clear", {err_parity, err_frame, err_overrun}, 0);
      chk("R1 no irq", n_itx + n_irx + n_ierr, 0);

      for (int i = 0; i < 6; i++) begin
         logic [7:0] vd;
         logic [1:0] vpm;
         bit vts, valt, pon;
         int bsrc, bt, nbits, tol;
         vd = VEC[i][7:0]; vpm = VEC[i][9:8]; vts = VEC[i][10];
         valt = VEC[i][13];
         bsrc = (int'(VEC[i][12:11]) + 1) * (valt ? 4 : 1);
         bt = 16 * bsrc;
         pon = (vpm == 2'b01 || vpm == 2'b10);
         nbits = 10 + (pon ? 1 : 0) + (vts ? 1 : 0);
         tol = 2 * bsrc + 3;
         @(negedge clk);
         use_alt = valt; baud_div = 16'(VEC[i][12:11]);
         par_mode = vpm; two_stop = vts;
         tick_n(4);

         tx_write(vd);
         tx_capture(bt, pon, vts, d, pb, sok, dt);
         chk($sformatf("R2 tx data vec%0d", i), d, vd);
         if (pon) chk($sformatf("R3 tx parity vec%0d", i), pb, (^vd) ^ (vpm == 2'b10));
         chk($sformatf("R4 stop bits high vec%0d", i), sok, 1);
         chk($sformatf("%s frame length vec%0d", valt ? "R6" : "R4", i),
             (dt >= nbits * bt - tol && dt <= nbits * bt + tol) ? 1 : 0, 1);

         k = n_irx; e = n_ierr;
         rx_send(vd, vpm, vts, bt, 1'b0, 1'b0);
         chk($sformatf("R7 rx full vec%0d", i), rx_hold_full, 1);
         chk($sformatf("R7 rx data vec%0d", i), rx_data, vd);
         chk($sformatf("R7 irq_rx vec%0d", i), n_irx - k, 1);
         chk($sformatf("R9 no false error vec%0d", i), n_ierr - e, 0);
         pulse_read();
         tick_n(1);
         chk($sformatf("R7 read clears vec%0d", i), rx_hold_full, 0);
      end

      // R5: load in the hand-off cycle is kept, load while full is dropped
      @(negedge clk);
      use_alt = 1'b0; baud_div = '0; par_mode = 2'b00; two_stop = 1'b0;
      tick_n(4);
      k = n_itx;
      @(negedge clk); tx_data = 8'h11; tx_load = 1'b1;
      @(negedge clk); tx_data = 8'h22;
      @(negedge clk); tx_data = 8'h33;
      @(negedge clk); tx_load = 1'b0;
      chk("R5 second byte held", tx_hold_full, 1);
      tx_capture(16, 1'b0, 1'b0, d, pb, sok, dt);
      chk("R5 first byte", d, 8'h11);
      tx_capture(16, 1'b0, 1'b0, d, pb, sok, dt);
      chk("R5 second byte", d, 8'h22);
      tick_n(3 * 16 * 10);
      chk("R5 third load ignored", n_itx - k, 2);
      chk("R5 hold empty after", tx_hold_full, 0);
      chk("R5 line idle", txd, 1);

      // R8: short low pulse is rejected
      @(negedge clk); par_mode = 2'b01;
      k = n_irx;
      @(negedge clk); rxd = 1'b0; tick_n(3); rxd = 1'b1;
      tick_n(80);
      chk("R8 glitch no byte", rx_hold_full, 0);
      chk("R8 glitch no irq", n_irx - k, 0);

      // R9: wrong parity
      e = n_ierr;
      rx_send(8'h5A, 2'b01, 1'b0, 16, 1'b1, 1'b0);
      chk("R9 parity flag", err_parity, 1);
      chk("R9 byte kept", rx_data, 8'h5A);
      chk("R12 irq_err pulse", n_ierr - e, 1);
      tick_n(50);
      chk("R12 parity sticky", err_parity, 1);
      pulse_read();
      pulse_clr();
      tick_n(1);
      chk("R12 parity cleared", err_parity, 0);

      // R10: low stop bit
      rx_send(8'hC3, 2'b01, 1'b0, 16, 1'b0, 1'b1);
      tick_n(40);
      chk("R10 frame flag", err_frame, 1);
      chk("R10 no parity flag", err_parity, 0);
      pulse_read();
      pulse_clr();
      tick_n(1);
      chk("R12 frame cleared", err_frame, 0);

      // R11: second byte while first unread
      k = n_irx; e = n_ierr;
      rx_send(8'h01, 2'b01, 1'b0, 16, 1'b0, 1'b0);
      rx_send(8'h02, 2'b01, 1'b0, 16, 1'b0, 1'b0);
      chk("R11 overrun flag", err_overrun, 1);
      chk("R11 old byte kept", rx_data, 8'h01);
      chk("R11 one irq_rx", n_irx - k, 1);
      chk("R11 one irq_err", n_ierr - e, 1);
      pulse_read();
      pulse_clr();
      tick_n(1);
      chk("R12 overrun cleared", err_overrun, 0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule